// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a multichannel sampling converter. A convert-start pulse, which may come from another clock domain, is synchronized and edge-detected. On an accepted start the block captures one sample from each of three main channels and from one of four auxiliary inputs, together with the channel-subset mode. It then runs a fixed hold period and converts the selected channels one after another. The analog path is modelled: sample values arrive as 11-bit two's complement words, and each conversion is a fixed count of clock cycles.

A busy flag is low while channels are being converted. The results of a run are written to the readable result bank in a single clock edge as the flag returns high. Until that edge a host reads the previous results over a parallel bus with chip-select, read strobe and a 2-bit address. Each 11-bit result sits in the upper bits of a 12-bit word, and the lowest bit is always zero.

Top module: `adc_seq_core`

## Requirements
- R1: After reset `busy_o` is 1 and all four result addresses read 0.
- R2: `start_i` passes through two flip-flops, and a run is accepted on its rising edge. Count as edge 1 the first rising clock edge that samples `start_i` high. `busy_o` is then first low after edge 23: 2 synchronizer edges, a 20-cycle hold and 1 edge to enter conversion.
- R3: `mode_i` selects the channels. 00 converts VIN2 and VIN3. 01 converts VIN2, VIN3 and AUX. 10 converts VIN1, VIN2 and VIN3. 11 converts all four. `busy_o` stays low for exactly n×40 cycles, where n is the number of channels.
- R4: Throughout the busy-low window every address returns the previous results. All converted results appear together in the first cycle in which `busy_o` is high again.
- R5: A channel that the mode does not convert keeps its previous result.
- R6: The address map is 00 for VIN1, 01 for VIN2, 10 for VIN3 and 11 for AUX. The read word is `{result[10:0], 1'b0}`.
- R7: While `cs_n` or `rd_n` is high, `data_o` is 0 and `data_oe_o` is 0. While both are low, `data_oe_o` is 1.
- R8: `auxsel_i` picks the AUX result from `aux_i[sel*11 +: 11]`, where sel is 0 to 3.
- R9: The mode, the aux select and all samples are taken at the accepted start. Changes to them after that point do not affect the run.
- R10: A start edge during the hold or the conversion is ignored. A start input that is held high begins only one run.
- R11: A reset asserted during a run aborts it. `busy_o` returns to 1 and every result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Asynchronous convert-start request |
| mode_i | input | 2 | Channel subset select |
| auxsel_i | input | 2 | Auxiliary input select |
| vin1_i | input | 11 | VIN1 sample |
| vin2_i | input | 11 | VIN2 sample |
| vin3_i | input | 11 | VIN3 sample |
| aux_i | input | 44 | Four auxiliary samples, 11 bits each |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_i | input | 2 | Result register address |
| data_o | output | 12 | Read data, left-justified |
| data_oe_o | output | 1 | Read data valid |
| busy_o | output | 1 | Low while channels convert |

## Verification
The main function is tried with all four mode codes and all four aux selects, using sample words that include the extremes 0x000, 0x7FF and 0x400. Because the results of unconverted channels must survive a run, mode 00 separates a masked commit from a full-bank write. After each accepted start the inputs are inverted, which tells an input latched at the start apart from one read live. Reads are made across the whole busy-low window, which catches an early or piecewise commit. A second start during conversion, a start held high and a reset during a run cover the cases where an edge is re-armed or a run is not aborted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CONV
    } seq_state_e;

    // bit i set = channel i converted (0 VIN1, 1 VIN2, 2 VIN3, 3 AUX)
    function automatic logic [NCH-1:0] mode_mask(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b0110;
            2'b01:   return 4'b1110;
            2'b10:   return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic edge_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = start_i;
        s_d.stable = s_q.meta;
        s_d.last   = s_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_o = s_q.stable & ~s_q.last;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int HOLD_CYC = 20,
    parameter int CONV_CYC = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_edge_i,
    input  logic [1:0]     mode_i,
    output logic           capture_o,
    output logic           commit_o,
    output logic           busy_o,
    output logic [NCH-1:0] mask_o
);
    localparam int HW = $clog2(HOLD_CYC);
    localparam int CW = $clog2(CONV_CYC);

    typedef struct packed {
        seq_state_e     state;
        logic [HW-1:0]  hold_cnt;
        logic [CW-1:0]  slot_cnt;
        logic [1:0]     chan;
        logic [NCH-1:0] mask;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  nxt_found;
    logic [1:0] nxt_chan;
    logic [1:0] first_chan;

    // lowest enabled channel above current, and lowest enabled overall
    always_comb begin
        nxt_found  = 1'b0;
        nxt_chan   = c_q.chan;
        first_chan = 2'd0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (c_q.mask[i] && i > int'(c_q.chan)) begin
                nxt_found = 1'b1;
                nxt_chan  = 2'(i);
            end
            if (c_q.mask[i]) first_chan = 2'(i);
        end
    end

    always_comb begin
        c_d       = c_q;
        capture_o = 1'b0;
        commit_o  = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start_edge_i) begin
                    c_d.state    = ST_HOLD;
                    c_d.hold_cnt = '0;
                    c_d.mask     = mode_mask(mode_i);
                    capture_o    = 1'b1;
                end
            end
            ST_HOLD: begin
                if (c_q.hold_cnt == HW'(HOLD_CYC - 1)) begin
                    c_d.state    = ST_CONV;
                    c_d.slot_cnt = '0;
                    c_d.chan     = first_chan;
                end else begin
                    c_d.hold_cnt = c_q.hold_cnt + 1'b1;
                end
            end
            default: begin
                if (c_q.slot_cnt == CW'(CONV_CYC - 1)) begin
                    c_d.slot_cnt = '0;
                    if (nxt_found) begin
                        c_d.chan = nxt_chan;
                    end else begin
                        commit_o  = 1'b1;
                        c_d.state = ST_IDLE;
                    end
                end else begin
                    c_d.slot_cnt = c_q.slot_cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign busy_o = (c_q.state != ST_CONV);
    assign mask_o = c_q.mask;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int SMP_W = 11,
    parameter int BUS_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic               commit_i,
    input  logic [NCH-1:0]     mask_i,
    input  logic [1:0]         auxsel_i,
    input  logic [SMP_W-1:0]   vin1_i,
    input  logic [SMP_W-1:0]   vin2_i,
    input  logic [SMP_W-1:0]   vin3_i,
    input  logic [NCH*SMP_W-1:0] aux_i,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic [1:0]         addr_i,
    output logic [BUS_W-1:0]   data_o,
    output logic               data_oe_o
);
    localparam int PAD = BUS_W - SMP_W;

    typedef struct packed {
        logic [NCH-1:0][SMP_W-1:0] held;
        logic [NCH-1:0][SMP_W-1:0] res;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (capture_i) begin
            b_d.held[0] = vin1_i;
            b_d.held[1] = vin2_i;
            b_d.held[2] = vin3_i;
            b_d.held[3] = aux_i[int'(auxsel_i)*SMP_W +: SMP_W];
        end
        if (commit_i) begin
            for (int i = 0; i < NCH; i++) begin
                if (mask_i[i]) b_d.res[i] = b_q.held[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data_oe_o = ~cs_n & ~rd_n;
    assign data_o    = data_oe_o ? {b_q.res[addr_i], {PAD{1'b0}}} : '0;
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int SMP_W    = 11,
    parameter int BUS_W    = 12,
    parameter int HOLD_CYC = 20,
    parameter int CONV_CYC = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic [1:0]           auxsel_i,
    input  logic [SMP_W-1:0]     vin1_i,
    input  logic [SMP_W-1:0]     vin2_i,
    input  logic [SMP_W-1:0]     vin3_i,
    input  logic [NCH*SMP_W-1:0] aux_i,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic [1:0]           addr_i,
    output logic [BUS_W-1:0]     data_o,
    output logic                 data_oe_o,
    output logic                 busy_o
);
    logic           start_edge;
    logic           capture;
    logic           commit;
    logic [NCH-1:0] mask;

    adc_start_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .edge_o (start_edge)
    );

    adc_seq_ctrl #(
        .HOLD_CYC(HOLD_CYC),
        .CONV_CYC(CONV_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_edge_i(start_edge),
        .mode_i      (mode_i),
        .capture_o   (capture),
        .commit_o    (commit),
        .busy_o      (busy_o),
        .mask_o      (mask)
    );

    adc_result_bank #(
        .SMP_W(SMP_W),
        .BUS_W(BUS_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(capture),
        .commit_i (commit),
        .mask_i   (mask),
        .auxsel_i (auxsel_i),
        .vin1_i   (vin1_i),
        .vin2_i   (vin2_i),
        .vin3_i   (vin3_i),
        .aux_i    (aux_i),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .addr_i   (addr_i),
        .data_o   (data_o),
        .data_oe_o(data_oe_o)
    );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int BUS_W    = 12,
    parameter int CONV_CYC = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             cs_n,
    input logic             rd_n,
    input logic [1:0]       addr_i,
    input logic [BUS_W-1:0] data_o,
    input logic             data_oe_o,
    input logic             capture,
    input logic             commit
);
    localparam int LW = $clog2(4 * CONV_CYC + 1) + 1;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt <= '0;
        else if (!busy_o) low_cnt <= low_cnt + 1'b1;
        else              low_cnt <= '0;
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && low_cnt != 0) |->
        (int'(low_cnt) == 2*CONV_CYC || int'(low_cnt) == 3*CONV_CYC ||
         int'(low_cnt) == 4*CONV_CYC));

    assert_atomic_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && $past(!cs_n && !rd_n) && $stable(addr_i) && !$rose(busy_o))
        |-> $stable(data_o));

    assert_commit_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> $rose(busy_o));

    assert_bus_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (data_o == '0 && !data_oe_o));

    assert_lsb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !data_o[0]);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> busy_o);
endmodule

bind adc_seq_core adc_seq_checker #(.BUS_W(BUS_W), .CONV_CYC(CONV_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .addr_i   (addr_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .capture  (capture),
    .commit   (commit)
);

// File: tb/adc_seq_core_tb.sv
module adc_seq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  auxsel_i = '0;
    logic [10:0] vin1_i = '0, vin2_i = '0, vin3_i = '0;
    logic [43:0] aux_i = '0;
    logic        cs_n = 1'b1, rd_n = 1'b1;
    logic [1:0]  addr_i = '0;
    logic [11:0] data_o;
    logic        data_oe_o, busy_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [10:0] model [4];

    always #2.5 clk = ~clk;

    adc_seq_core dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .auxsel_i(auxsel_i), .vin1_i(vin1_i), .vin2_i(vin2_i), .vin3_i(vin3_i),
        .aux_i(aux_i), .cs_n(cs_n), .rd_n(rd_n), .addr_i(addr_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .busy_o(busy_o)
    );

    // {mode, auxsel, vin1, vin2, vin3, selected aux}
    localparam logic [47:0] VEC [6] = '{
        {2'b00, 2'd0, 11'h123, 11'h234, 11'h345, 11'h056},
        {2'b01, 2'd2, 11'h7FF, 11'h400, 11'h001, 11'h3AA},
        {2'b10, 2'd1, 11'h555, 11'h2AA, 11'h0F0, 11'h111},
        {2'b11, 2'd3, 11'h000, 11'h7AB, 11'h1CD, 11'h6EF},
        {2'b11, 2'd0, 11'h321, 11'h432, 11'h543, 11'h654},
        {2'b01, 2'd1, 11'h0AA, 11'h155, 11'h200, 11'h3FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [11:0] v);
        addr_i = a; cs_n = 1'b0; rd_n = 1'b0;
        #1 v = data_o;
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] m);
        case (m)
            2'b00: return 4'b0110;
            2'b01: return 4'b1110;
            2'b10: return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic read_all(input string req);
        logic [11:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(req, {20'd0, v}, {20'd0, model[a], 1'b0});
        end
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        logic [11:0] v;
        int n, lc, nch;
        bit old_ok;
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy_o}, 32'd1);
        read_all("R1 reset read");
        // R7 bus idle with cs high
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R7 cs high", {19'd0, data_oe_o, data_o}, 32'd0);
        rd_n = 1'b1;

        for (int k = 0; k < 6; k++) begin
            logic [47:0] e;
            e = VEC[k];
            @(negedge clk);
            mode_i = e[47:46]; auxsel_i = e[45:44];
            vin1_i = e[43:33]; vin2_i = e[32:22]; vin3_i = e[21:11];
            for (int s = 0; s < 4; s++)
                aux_i[s*11 +: 11] = (s == int'(e[45:44])) ? e[10:0] : (e[10:0] ^ 11'h7FF ^ 11'(s));
            start_i = 1'b1;
            n = 0;
            do begin @(posedge clk); n++; @(negedge clk); end while (busy_o && n < 100);
            chk("R2 start to busy low", n, 23);
            start_i = 1'b0;
            // R9: scramble inputs after acceptance
            mode_i = ~mode_i; auxsel_i = ~auxsel_i;
            vin1_i = ~vin1_i; vin2_i = ~vin2_i; vin3_i = ~vin3_i; aux_i = ~aux_i;
            lc = 0; old_ok = 1;
            while (!busy_o && lc < 400) begin
                lc++;
                if (lc == 10) start_i = 1'b1;   // R10 start during conversion
                if (lc == 14) start_i = 1'b0;
                rd(2'(lc % 4), v);
                if (v !== {model[lc % 4], 1'b0}) old_ok = 0;
                @(negedge clk);
            end
            cs_n = 1'b1; rd_n = 1'b1;
            nch = $countones(exp_mask(e[47:46]));
            chk("R3 busy low length", lc, nch * 40);
            chk("R4 old data held", {31'd0, old_ok}, 32'd1);
            // R5/R6/R8/R9 model commit
            if (exp_mask(e[47:46])[0]) model[0] = e[43:33];
            if (exp_mask(e[47:46])[1]) model[1] = e[32:22];
            if (exp_mask(e[47:46])[2]) model[2] = e[21:11];
            if (exp_mask(e[47:46])[3]) model[3] = e[10:0];
            read_all("R4 R5 R6 R8 R9 new data");
            repeat (30) @(negedge clk);
            chk("R10 ignored start", {31'd0, busy_o}, 32'd1);
        end

        // R10 start held high: one run only
        @(negedge clk);
        mode_i = 2'b00; vin2_i = 11'h0C3; vin3_i = 11'h13C;
        start_i = 1'b1;
        n = 0;
        while (busy_o && n < 100) begin @(negedge clk); n++; end
        lc = 0;
        while (!busy_o && lc < 400) begin @(negedge clk); lc++; end
        repeat (60) @(negedge clk);
        chk("R10 held start single run", {31'd0, busy_o}, 32'd1);
        start_i = 1'b0;
        model[1] = 11'h0C3; model[2] = 11'h13C;
        read_all("R10 held start data");

        // R11 reset mid run
        @(negedge clk);
        mode_i = 2'b11; start_i = 1'b1;
        n = 0;
        while (busy_o && n < 100) begin @(negedge clk); n++; end
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after abort", {31'd0, busy_o}, 32'd1);
        for (int i = 0; i < 4; i++) model[i] = '0;
        read_all("R11 regs cleared");
        repeat (200) @(negedge clk);
        chk("R11 no resumed run", {31'd0, busy_o}, 32'd1);

        finish_run();
    end
endmodule